// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider with Quadrature Phases

This block divides a reference clock by a ratio chosen at run time from a 5-bit code. The ratio can be an integer or lie halfway between two integers. Both clocks are modelled as registered signals in a sampling clock domain. The sampling clock runs at four times the reference frequency, so one sampling cycle is one quarter of a reference period. A reference edge, rising or falling, falls every two sampling cycles. The divider counts reference half-periods. Because it can act on either edge of the reference, a half-integer ratio costs no extra hardware.

The divided output keeps its duty cycle as close to even as the ratio allows. A companion bus carries the reference clock in four quadrature phases, all derived from one quarter-period counter. As a result, every output edge lines up with a reference edge. A new ratio code is taken only when the divided output starts a new period. A change therefore never shortens a pulse that is already in progress.

Top module: `halfstep_clk_divider`

## Requirements
- R1: While the synchronous reset is sampled high, the divided output is low and quad_o equals 4'b1100. After release, the divider runs at ratio 2 until the first period boundary.
- R2: Codes 12 to 20 select the integer ratio (code - 4), which covers 8 to 16. Codes 0 to 11 select the ratio (code + 3) / 2, which covers 1.5 to 7 in steps of 0.5. One output period lasts 2 x ratio reference half-periods, and each half-period is two sampling cycles.
- R3: Codes 21 to 31 act exactly as ratio 2.
- R4: A period of H reference half-periods starts with ceil(H/2) half-periods high, followed by floor(H/2) half-periods low. Integer ratios from 2 to 7 therefore give an exact 50/50 split or differ from it by one half-period.
- R5: At a half-integer ratio, the output's rising edges fall alternately on rising and on falling edges of the 0° phase.
- R6: quad_o[k] is the reference clock delayed by k quarter-periods, for k = 0 to 3, which gives 0°, 90°, 180° and 270°. On the first clock edge after reset release, quad_o[0] rises. Each bit is high for two cycles and then low for two. The divided output changes only in cycles where quad_o[0] also changes.
- R7: The ratio code is sampled only on the edge where a new output period begins. A code that is present only during the middle of a period has no effect on the output.
- R8: Asserting the reset in the middle of operation returns every output to the R1 state on the next edge. After release, the sequence restarts exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, four cycles per reference period |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_sel_i | input | 5 | Division ratio code |
| div_clk_o | output | 1 | Divided clock, registered |
| quad_o | output | 4 | Reference clock phases 0°, 90°, 180°, 270° (bit 0 = 0°) |

## Verification
The bench builds the block with its default package values: a 5-bit code, twelve half-step codes and nine integer codes. With these values the bench can sweep every code, including the eleven unused ones, and hold each code for three full periods. This exercises both ends of the range: ratio 1.5, where the output is low for only one half-period, and ratio 16, where the 6-bit half-period counter reaches 31. The bench also changes the code every few cycles to probe boundary sampling, and it resets the block mid-stream.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  localparam int CODE_W      = 5;
  localparam int HALF_CODES  = 12;  // codes giving x.0/x.5 ratios from 1.5
  localparam int INT_CODES   = 9;   // codes giving integer ratios
  localparam int MIN_HALVES  = 3;   // ratio 1.5 expressed in half-periods
  localparam int FIRST_INT   = 8;   // first ratio of the integer range
  localparam int DEF_HALVES  = 4;   // ratio 2
  localparam int PH_N        = 4;   // quadrature phase count
  localparam int MAX_HALVES  = 2 * (FIRST_INT + INT_CODES - 1);
  localparam int HALVES_W    = $clog2(MAX_HALVES + 1);
  typedef logic [HALVES_W-1:0] halves_t;
endpackage

// File: rtl/hdiv_ratio_decode.sv
module hdiv_ratio_decode
  import hdiv_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int N_HALF = HALF_CODES,
  parameter int N_INT  = INT_CODES
) (
  input  logic [CW-1:0] code_i,
  output halves_t       halves_o
);
  localparam int LAST_CODE = N_HALF + N_INT - 1;

  always_comb begin
    int c;
    c = int'(code_i);
    if (c < N_HALF)
      halves_o = halves_t'(c + MIN_HALVES);
    else if (c <= LAST_CODE)
      halves_o = halves_t'(2 * (c - N_HALF + FIRST_INT));
    else
      halves_o = halves_t'(DEF_HALVES);
  end
endmodule

// File: rtl/hdiv_quad_gen.sv
module hdiv_quad_gen
  import hdiv_pkg::*;
#(
  parameter int NPH = PH_N
) (
  input  logic           clk_i,
  input  logic           rst_i,
  output logic           edge_next_o,  // next clock edge is a reference edge
  output logic [NPH-1:0] quad_o
);
  localparam int QW = $clog2(NPH);

  logic [QW-1:0] qtr_q;
  logic [QW-1:0] qtr_nxt;

  assign qtr_nxt     = qtr_q + 1'b1;
  assign edge_next_o = qtr_q[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) qtr_q <= QW'(NPH - 1);
    else       qtr_q <= qtr_nxt;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    localparam logic [QW-1:0] K = QW'(k);
    logic [QW-1:0] rel;
    logic [QW-1:0] rel_rst;
    assign rel     = qtr_nxt - K;
    assign rel_rst = QW'(NPH - 1) - K;
    always_ff @(posedge clk_i) begin
      if (rst_i) quad_o[k] <= (int'(rel_rst) < NPH / 2);
      else       quad_o[k] <= (int'(rel) < NPH / 2);
    end
  end

  p_quad_rotate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> quad_o == {$past(quad_o[NPH-2:0]), $past(quad_o[NPH-1])});

  p_quad_half_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(quad_o) == NPH / 2);
endmodule

// File: rtl/hdiv_divider.sv
module hdiv_divider
  import hdiv_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  logic    edge_next_i,
  input  halves_t halves_i,
  output logic    div_o
);
  halves_t act_q;
  halves_t cnt_q;
  logic    last_half;
  logic [HALVES_W:0] hi_len;
  logic [HALVES_W:0] cnt_inc;

  assign last_half = (cnt_q == act_q - 1'b1);
  assign hi_len    = ({1'b0, act_q} + 1'b1) >> 1;
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= halves_t'(DEF_HALVES);
      cnt_q <= halves_t'(DEF_HALVES - 1);
      div_o <= 1'b0;
    end else if (edge_next_i) begin
      if (last_half) begin
        act_q <= halves_i;
        cnt_q <= '0;
        div_o <= 1'b1;
      end else begin
        cnt_q <= cnt_inc[HALVES_W-1:0];
        div_o <= (cnt_inc < hi_len);
      end
    end
  end

  p_cnt_below_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < act_q);

  p_rise_at_start_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(div_o) |-> cnt_q == '0);

  p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(edge_next_i && last_half) |=> $stable(act_q));

  p_ratio_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    act_q >= halves_t'(MIN_HALVES) && act_q <= halves_t'(MAX_HALVES));
endmodule

// File: rtl/halfstep_clk_divider.sv
module halfstep_clk_divider
  import hdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] ratio_sel_i,
  output logic              div_clk_o,
  output logic [PH_N-1:0]   quad_o
);
  halves_t sel_halves;
  logic    edge_next;

  hdiv_ratio_decode #(
    .CW     (CODE_W),
    .N_HALF (HALF_CODES),
    .N_INT  (INT_CODES)
  ) u_decode (
    .code_i   (ratio_sel_i),
    .halves_o (sel_halves)
  );

  hdiv_quad_gen #(.NPH(PH_N)) u_quad (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .edge_next_o (edge_next),
    .quad_o      (quad_o)
  );

  hdiv_divider u_div (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .edge_next_i (edge_next),
    .halves_i    (sel_halves),
    .div_o       (div_clk_o)
  );

  p_edge_align_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(div_clk_o) |-> !$stable(quad_o[0]));

  p_rst_low_r1: assert property (@(posedge clk_i)
    rst_i |=> (!div_clk_o && quad_o == 4'b1100) || rst_i);
endmodule

// File: tb/tb_halfstep_clk_divider.sv
module tb_halfstep_clk_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] sel = 5'd1;
  logic       div_clk;
  logic [3:0] quad;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit       dv;
    bit [3:0] qd;
    string    req;
  } exp_t;
  exp_t sb[$];

  // reference model state
  int mq = 3, mh = 3, mH = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfstep_clk_divider dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .ratio_sel_i (sel),
    .div_clk_o   (div_clk),
    .quad_o      (quad)
  );

  // R2/R3: half-periods per output period for a code
  function automatic int code_halves(int c);
    if (c <= 11)      return c + 3;
    else if (c <= 20) return 2 * (c - 4);
    else              return 4;
  endfunction

  task automatic step(input int code, input bit r, input string req);
    exp_t e;
    @(negedge clk);
    sel = code[4:0];
    rst = r;
    if (r) begin
      mq = 3; mh = 3; mH = 4;
    end else begin
      mq = (mq + 1) % 4;
      if (mq % 2 == 0) begin
        if (mh == mH - 1) begin
          mH = code_halves(code);
          mh = 0;
        end else mh++;
      end
    end
    e.dv = (mh < (mH + 1) / 2);
    for (int k = 0; k < 4; k++) e.qd[k] = (((mq - k + 4) % 4) < 2);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic run(input int code, input int n, input string req);
    for (int i = 0; i < n; i++) step(code, 1'b0, req);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (div_clk !== e.dv) begin
        errors++;
        $display("FAIL %s div_clk actual=%b expected=%b t=%0t", e.req, div_clk, e.dv, $time);
      end
      checks++;
      if (quad !== e.qd) begin
        errors++;
        $display("FAIL R6 quad actual=%b expected=%b t=%0t", quad, e.qd, $time);
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and default ratio 2
    for (int i = 0; i < 3; i++) step(1, 1'b1, "R1");
    run(25, 40, "R1");
    // sweep every code for three periods; R2 integers, R4 duty, R5 half steps, R3 unused
    for (int c = 0; c < 32; c++) begin
      string lbl;
      if (c > 20)          lbl = "R3";
      else if (c >= 12)    lbl = "R2";
      else if (c % 2 == 0) lbl = "R5";
      else                 lbl = "R4";
      run(c, 3 * 2 * code_halves(c) + 8, lbl);
    end
    // R7: code changes every few cycles, only boundary values count
    for (int i = 0; i < 120; i++) run((i * 7) % 32, 3, "R7");
    run(20, 20, "R7");
    run(0, 30, "R7");
    // R8: reset in mid-period, then restart
    run(14, 13, "R8");
    step(14, 1'b1, "R8");
    step(14, 1'b1, "R8");
    run(0, 40, "R8");
    // R5: long run at ratio 6.5 after restart
    run(10, 80, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule